// File: doc/BRIEF.md
# Extension Instruction Predecoder with Operation Remap

This block sits beside the fetch stage of a simple in-order core and looks at every fetched 32-bit instruction word. A word whose primary opcode holds the single value reserved for extensions is taken apart into three pieces: an extension instruction code, a short operation opcode and the register operand fields. These pieces are sent on toward the pre-processing stage. Any other word goes unchanged to the core's normal decode path. The result is registered, so it appears one clock after the fetch.

The short opcode does not name an operation directly. It indexes a 64-entry table of 16-bit operation identifiers. The table can be rewritten while the core runs, so one opcode can name a different operation later on. Each of up to four compute units owns an inclusive identifier window, set by a programmable base and limit. The identifier is compared against these windows. The block then raises a start for the matching unit and gives the identifier's offset from that unit's base as a local operation index. An identifier that falls in no window is flagged as illegal, and no unit is started.

Top module: `ext_predecode_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `core_valid`, `ext_valid`, `ext_illegal` are 0 and `cu_start` is 4'b0000.
- R2: A fetched word (`fetch_valid`=1) with bits [31:26] equal to 6'h3F yields `ext_valid`=1 and `core_valid`=0 one clock later.
- R3: A fetched word with any other value in bits [31:26] yields `core_valid`=1 with `core_word` equal to the fetched word one clock later, `ext_valid`=0, `cu_start`=0 and `ext_illegal`=0.
- R4: With `fetch_valid`=0, neither `core_valid` nor `ext_valid` is raised one clock later, and `cu_start` is 0.
- R5: For an extension word the outputs are `ext_code`=bits[10:6], `ext_opc`=bits[5:0], `ext_rs`=bits[25:21], `ext_rt`=bits[20:16] and `ext_rd`=bits[15:11].
- R6: `ext_op_id` is the table entry indexed by the opcode in bits[5:0]. Every entry is 16'h0000 after reset.
- R7: A table write (`tbl_we`, `tbl_waddr`, `tbl_wdata`) changes what later lookups of that entry return and leaves every other entry unchanged.
- R8: When a table write and a lookup address the same entry in the same cycle, the lookup returns the newly written identifier.
- R9: Unit k matches when `rng_base[k]` <= id <= `rng_limit[k]`. A match raises only `cu_start[k]` and sets `cu_local_idx` to id minus base.
- R10: When several windows contain the identifier, the unit with the lowest index is selected.
- R11: An extension word whose identifier lies in no window gives `ext_illegal`=1 and `cu_start`=0. After reset every window is empty (base 16'hFFFF, limit 16'h0000).
- R12: A window write (`rng_we`, `rng_sel`, `rng_base`, `rng_limit`) affects lookups from the next cycle on. A fetch in the same cycle as the write is routed with the old window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetched word is valid |
| fetch_word | input | 32 | Fetched instruction word |
| tbl_we | input | 1 | Remap table write enable |
| tbl_waddr | input | 6 | Remap table entry to write |
| tbl_wdata | input | 16 | Operation identifier to store |
| rng_we | input | 1 | Unit window write enable |
| rng_sel | input | 2 | Unit whose window is written |
| rng_base | input | 16 | Lowest identifier of the window |
| rng_limit | input | 16 | Highest identifier of the window |
| core_valid | output | 1 | Word routed to normal decode |
| core_word | output | 32 | Word for normal decode |
| ext_valid | output | 1 | Extension word routed to pre-processing |
| ext_code | output | 5 | Extension instruction code |
| ext_opc | output | 6 | Short operation opcode |
| ext_rs | output | 5 | First source register field |
| ext_rt | output | 5 | Second source register field |
| ext_rd | output | 5 | Destination register field |
| ext_op_id | output | 16 | Remapped operation identifier |
| cu_start | output | 4 | One-hot compute unit start |
| cu_local_idx | output | 16 | Identifier offset within the selected unit |
| ext_illegal | output | 1 | Identifier matched no unit |

## Verification
The hardest cases to create from the ports are the ones where a configuration write and a fetch land on the same cycle. A table write to the entry being looked up must be forwarded at once. A window write in the same cycle must not be seen yet. The stimulus drives the write and the fetch together on one clock and then repeats the fetch on the next clock, so both sides of the timing are checked. Overlapping windows and identifiers placed exactly on a base or a limit are set up before the vector loop, so that priority and the inclusive bounds are each hit by at least one vector.

// File: rtl/ext_pkg.sv
package ext_pkg;
  localparam int INSTR_W   = 32;
  localparam int PRIM_W    = 6;
  localparam int CODE_W    = 5;
  localparam int OPC_W     = 6;
  localparam int REG_W     = 5;
  localparam int ID_W      = 16;
  localparam int N_CU      = 4;
  localparam logic [PRIM_W-1:0] EXT_PRIMARY = 6'h3F;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [OPC_W-1:0]  opc;
    logic [REG_W-1:0]  rs;
    logic [REG_W-1:0]  rt;
    logic [REG_W-1:0]  rd;
  } ext_fields_t;
endpackage

// File: rtl/ext_word_split.sv
module ext_word_split
  import ext_pkg::*;
#(
  parameter logic [PRIM_W-1:0] PRIMARY = EXT_PRIMARY
) (
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] word_i,
  output logic               is_ext_o,
  output logic               is_core_o,
  output ext_fields_t        fields_o
);
  localparam int PRIM_LSB = INSTR_W - PRIM_W;
  localparam int RS_LSB   = PRIM_LSB - REG_W;
  localparam int RT_LSB   = RS_LSB - REG_W;
  localparam int RD_LSB   = RT_LSB - REG_W;

  function automatic logic prim_match(input logic [INSTR_W-1:0] w);
    return w[INSTR_W-1:PRIM_LSB] == PRIMARY;
  endfunction

  logic prim_hit;
  assign prim_hit  = prim_match(word_i);
  assign is_ext_o  = valid_i && prim_hit;
  assign is_core_o = valid_i && !prim_hit;

  assign fields_o.rs   = word_i[RS_LSB +: REG_W];
  assign fields_o.rt   = word_i[RT_LSB +: REG_W];
  assign fields_o.rd   = word_i[RD_LSB +: REG_W];
  assign fields_o.code = word_i[OPC_W +: CODE_W];
  assign fields_o.opc  = word_i[0 +: OPC_W];
endmodule

// File: rtl/ext_remap_table.sv
module ext_remap_table
  import ext_pkg::*;
#(
  parameter int AW = OPC_W,
  parameter int DW = ID_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          bypass_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign bypass_hit = we_i && (waddr_i == raddr_i);
  assign rdata_o    = bypass_hit ? wdata_i : mem[raddr_i];

  // R7
  table_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> mem[$past(waddr_i)] == $past(wdata_i));

  // R8
  table_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_hit |-> rdata_o == wdata_i);
endmodule

// File: rtl/ext_unit_router.sv
module ext_unit_router
  import ext_pkg::*;
#(
  parameter int NU = N_CU,
  parameter int DW = ID_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we_i,
  input  logic [$clog2(NU)-1:0] cfg_sel_i,
  input  logic [DW-1:0]         cfg_base_i,
  input  logic [DW-1:0]         cfg_limit_i,
  input  logic [DW-1:0]         id_i,
  output logic [NU-1:0]         sel_o,
  output logic [DW-1:0]         local_o,
  output logic                  none_o
);
  localparam int SW = $clog2(NU);

  function automatic logic in_window(input logic [DW-1:0] id,
                                     input logic [DW-1:0] lo,
                                     input logic [DW-1:0] hi);
    return (id >= lo) && (id <= hi);
  endfunction

  function automatic logic [NU-1:0] lowest_set(input logic [NU-1:0] v);
    logic [NU-1:0] r;
    r = '0;
    for (int k = NU - 1; k >= 0; k--) begin
      if (v[k]) r = NU'(1) << k;
    end
    return r;
  endfunction

  logic [DW-1:0] base_q  [NU];
  logic [DW-1:0] limit_q [NU];
  logic [NU-1:0] hit;
  logic [DW-1:0] sel_base;

  for (genvar k = 0; k < NU; k++) begin : g_unit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[k]  <= '1;
        limit_q[k] <= '0;
      end else if (cfg_we_i && cfg_sel_i == SW'(k)) begin
        base_q[k]  <= cfg_base_i;
        limit_q[k] <= cfg_limit_i;
      end
    end
    assign hit[k] = in_window(id_i, base_q[k], limit_q[k]);
  end

  assign sel_o  = lowest_set(hit);
  assign none_o = (hit == '0);

  always_comb begin
    sel_base = '0;
    for (int k = 0; k < NU; k++) begin
      if (sel_o[k]) sel_base = base_q[k];
    end
  end

  assign local_o = id_i - sel_base;

  // R9
  router_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o) && (none_o == (sel_o == '0)));

  // R9
  router_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !none_o |-> (local_o <= id_i));
endmodule

// File: rtl/ext_predecode_top.sv
module ext_predecode_top
  import ext_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fetch_valid,
  input  logic [31:0]           fetch_word,
  input  logic                  tbl_we,
  input  logic [5:0]            tbl_waddr,
  input  logic [15:0]           tbl_wdata,
  input  logic                  rng_we,
  input  logic [1:0]            rng_sel,
  input  logic [15:0]           rng_base,
  input  logic [15:0]           rng_limit,
  output logic                  core_valid,
  output logic [31:0]           core_word,
  output logic                  ext_valid,
  output logic [4:0]            ext_code,
  output logic [5:0]            ext_opc,
  output logic [4:0]            ext_rs,
  output logic [4:0]            ext_rt,
  output logic [4:0]            ext_rd,
  output logic [15:0]           ext_op_id,
  output logic [3:0]            cu_start,
  output logic [15:0]           cu_local_idx,
  output logic                  ext_illegal
);
  logic          is_ext;
  logic          is_core;
  ext_fields_t   fields;
  logic [ID_W-1:0] op_id;
  logic [N_CU-1:0] unit_sel;
  logic [ID_W-1:0] local_idx;
  logic            no_unit;

  ext_word_split #(.PRIMARY(EXT_PRIMARY)) i_split (
    .valid_i   (fetch_valid),
    .word_i    (fetch_word),
    .is_ext_o  (is_ext),
    .is_core_o (is_core),
    .fields_o  (fields)
  );

  ext_remap_table #(.AW(OPC_W), .DW(ID_W)) i_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (tbl_we),
    .waddr_i (tbl_waddr),
    .wdata_i (tbl_wdata),
    .raddr_i (fields.opc),
    .rdata_o (op_id)
  );

  ext_unit_router #(.NU(N_CU), .DW(ID_W)) i_router (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we_i    (rng_we),
    .cfg_sel_i   (rng_sel),
    .cfg_base_i  (rng_base),
    .cfg_limit_i (rng_limit),
    .id_i        (op_id),
    .sel_o       (unit_sel),
    .local_o     (local_idx),
    .none_o      (no_unit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_valid   <= 1'b0;
      core_word    <= '0;
      ext_valid    <= 1'b0;
      ext_code     <= '0;
      ext_opc      <= '0;
      ext_rs       <= '0;
      ext_rt       <= '0;
      ext_rd       <= '0;
      ext_op_id    <= '0;
      cu_start     <= '0;
      cu_local_idx <= '0;
      ext_illegal  <= 1'b0;
    end else begin
      core_valid   <= is_core;
      core_word    <= fetch_word;
      ext_valid    <= is_ext;
      ext_code     <= fields.code;
      ext_opc      <= fields.opc;
      ext_rs       <= fields.rs;
      ext_rt       <= fields.rt;
      ext_rd       <= fields.rd;
      ext_op_id    <= op_id;
      cu_start     <= is_ext ? unit_sel : '0;
      cu_local_idx <= local_idx;
      ext_illegal  <= is_ext && no_unit;
    end
  end

  // R2
  path_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_valid && ext_valid));

  // R11
  illegal_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_illegal |-> (cu_start == '0));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> (!core_valid && !ext_valid && cu_start == '0));

  // R3
  core_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_core |=> (core_word == $past(fetch_word) && cu_start == '0 && !ext_illegal));

  // R9
  start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cu_start) && (ext_valid || cu_start == '0));
endmodule

// File: tb/test_ext_predecode_top.sv
module test_ext_predecode_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_word = '0;
  logic        tbl_we = 1'b0;
  logic [5:0]  tbl_waddr = '0;
  logic [15:0] tbl_wdata = '0;
  logic        rng_we = 1'b0;
  logic [1:0]  rng_sel = '0;
  logic [15:0] rng_base = '0;
  logic [15:0] rng_limit = '0;
  logic        core_valid, ext_valid, ext_illegal;
  logic [31:0] core_word;
  logic [4:0]  ext_code, ext_rs, ext_rt, ext_rd;
  logic [5:0]  ext_opc;
  logic [15:0] ext_op_id, cu_local_idx;
  logic [3:0]  cu_start;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ext_predecode_top i_ext_predecode_top (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .rng_we(rng_we), .rng_sel(rng_sel), .rng_base(rng_base), .rng_limit(rng_limit),
    .core_valid(core_valid), .core_word(core_word), .ext_valid(ext_valid),
    .ext_code(ext_code), .ext_opc(ext_opc), .ext_rs(ext_rs), .ext_rt(ext_rt),
    .ext_rd(ext_rd), .ext_op_id(ext_op_id), .cu_start(cu_start),
    .cu_local_idx(cu_local_idx), .ext_illegal(ext_illegal)
  );

  typedef struct packed {
    logic [31:0] w;
    logic [15:0] id;
    logic [3:0]  st;
    logic [15:0] loc;
    logic        ill;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{ {6'h3F,5'd1,5'd2,5'd3,5'd4,6'd1},   16'h0005, 4'b0001, 16'h0005, 1'b0 },
    '{ {6'h3F,5'd7,5'd8,5'd9,5'd10,6'd2},  16'h0150, 4'b0010, 16'h0050, 1'b0 },
    '{ {6'h3F,5'd31,5'd0,5'd17,5'd3,6'd3}, 16'h01A0, 4'b0010, 16'h00A0, 1'b0 },
    '{ {6'h3F,5'd4,5'd5,5'd6,5'd0,6'd4},   16'h0800, 4'b1000, 16'h0680, 1'b0 },
    '{ {6'h3F,5'd11,5'd22,5'd30,5'd21,6'd5},16'h1234, 4'b0100, 16'h0234, 1'b0 },
    '{ {6'h3F,5'd2,5'd2,5'd2,5'd2,6'd6},   16'h2000, 4'b0000, 16'h0000, 1'b1 },
    '{ {6'h3F,5'd3,5'd1,5'd4,5'd1,6'd7},   16'h00FF, 4'b0001, 16'h00FF, 1'b0 },
    '{ {6'h3F,5'd9,5'd26,5'd5,5'd31,6'd8}, 16'h1FFF, 4'b0100, 16'h0FFF, 1'b0 },
    '{ {6'h3F,5'd0,5'd0,5'd1,5'd0,6'd9},   16'h1000, 4'b0100, 16'h0000, 1'b0 },
    '{ 32'h8C41_0010,                       16'h0000, 4'b0000, 16'h0000, 1'b0 },
    '{ 32'hFC00_0000 ^ 32'h0400_0000,       16'h0000, 4'b0000, 16'h0000, 1'b0 }
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_inputs();
    fetch_valid = 1'b0; tbl_we = 1'b0; rng_we = 1'b0;
  endtask

  task automatic twrite(input logic [5:0] a, input logic [15:0] d);
    tbl_we = 1'b1; tbl_waddr = a; tbl_wdata = d;
    tick();
    tbl_we = 1'b0;
  endtask

  task automatic rwrite(input logic [1:0] s, input logic [15:0] b, input logic [15:0] l);
    rng_we = 1'b1; rng_sel = s; rng_base = b; rng_limit = l;
    tick();
    rng_we = 1'b0;
  endtask

  function automatic logic [31:0] ext_word(input logic [5:0] opc);
    return {6'h3F, 5'd1, 5'd2, 5'd3, 5'd0, opc};
  endfunction

  task automatic check_vec(input vec_t v);
    logic is_ext;
    is_ext = (v.w[31:26] == 6'h3F);
    fetch_valid = 1'b1; fetch_word = v.w;
    tick();
    fetch_valid = 1'b0;
    chk("R2 ext_valid", {31'd0, ext_valid}, {31'd0, is_ext});
    chk("R3 core_valid", {31'd0, core_valid}, {31'd0, !is_ext});
    if (is_ext) begin
      chk("R5 ext_code", {27'd0, ext_code}, {27'd0, v.w[10:6]});
      chk("R5 ext_opc", {26'd0, ext_opc}, {26'd0, v.w[5:0]});
      chk("R5 ext_rs", {27'd0, ext_rs}, {27'd0, v.w[25:21]});
      chk("R5 ext_rt", {27'd0, ext_rt}, {27'd0, v.w[20:16]});
      chk("R5 ext_rd", {27'd0, ext_rd}, {27'd0, v.w[15:11]});
      chk("R6 ext_op_id", {16'd0, ext_op_id}, {16'd0, v.id});
      if (!v.ill) chk("R9 cu_local_idx", {16'd0, cu_local_idx}, {16'd0, v.loc});
    end else begin
      chk("R3 core_word", core_word, v.w);
    end
    chk("R9 R10 cu_start", {28'd0, cu_start}, {28'd0, v.st});
    chk("R11 ext_illegal", {31'd0, ext_illegal}, {31'd0, v.ill});
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) tick();
    // R1: outputs held quiet during reset
    fetch_valid = 1'b1; fetch_word = ext_word(6'd0);
    tick();
    chk("R1 ext_valid in reset", {31'd0, ext_valid}, 32'd0);
    chk("R1 core_valid in reset", {31'd0, core_valid}, 32'd0);
    chk("R1 cu_start in reset", {28'd0, cu_start}, 32'd0);
    fetch_valid = 1'b0;
    rst_n = 1'b1;
    tick();
    chk("R1 ext_valid after reset", {31'd0, ext_valid}, 32'd0);
    chk("R1 ext_illegal after reset", {31'd0, ext_illegal}, 32'd0);

    // R11 R6: empty windows and zero table after reset
    fetch_valid = 1'b1; fetch_word = ext_word(6'd33);
    tick();
    fetch_valid = 1'b0;
    chk("R6 reset entry zero", {16'd0, ext_op_id}, 32'd0);
    chk("R11 reset windows empty", {31'd0, ext_illegal}, 32'd1);
    chk("R11 no start", {28'd0, cu_start}, 32'd0);

    // configure windows (unit3 overlaps unit1)
    rwrite(2'd0, 16'h0000, 16'h00FF);
    rwrite(2'd1, 16'h0100, 16'h01FF);
    rwrite(2'd2, 16'h1000, 16'h1FFF);
    rwrite(2'd3, 16'h0180, 16'h0FFF);
    twrite(6'd1, 16'h0005);
    twrite(6'd2, 16'h0150);
    twrite(6'd3, 16'h01A0);
    twrite(6'd4, 16'h0800);
    twrite(6'd5, 16'h1234);
    twrite(6'd6, 16'h2000);
    twrite(6'd7, 16'h00FF);
    twrite(6'd8, 16'h1FFF);
    twrite(6'd9, 16'h1000);

    for (int i = 0; i < NV; i++) check_vec(VECS[i]);

    // R4: no fetch, no output
    fetch_valid = 1'b0; fetch_word = ext_word(6'd1);
    tick();
    chk("R4 ext_valid idle", {31'd0, ext_valid}, 32'd0);
    chk("R4 core_valid idle", {31'd0, core_valid}, 32'd0);
    chk("R4 cu_start idle", {28'd0, cu_start}, 32'd0);

    // R8: same-cycle write and lookup
    tbl_we = 1'b1; tbl_waddr = 6'd10; tbl_wdata = 16'h0042;
    fetch_valid = 1'b1; fetch_word = ext_word(6'd10);
    tick();
    clear_inputs();
    chk("R8 bypass id", {16'd0, ext_op_id}, 32'h0042);
    chk("R8 bypass start", {28'd0, cu_start}, 32'b0001);
    chk("R8 bypass local", {16'd0, cu_local_idx}, 32'h0042);

    // R7: rewrite entry 1, entry 2 untouched
    twrite(6'd1, 16'h1001);
    fetch_valid = 1'b1; fetch_word = ext_word(6'd1);
    tick();
    chk("R7 rewritten id", {16'd0, ext_op_id}, 32'h1001);
    chk("R7 rewritten start", {28'd0, cu_start}, 32'b0100);
    chk("R7 rewritten local", {16'd0, cu_local_idx}, 32'h0001);
    fetch_word = ext_word(6'd2);
    tick();
    fetch_valid = 1'b0;
    chk("R7 neighbour unchanged", {16'd0, ext_op_id}, 32'h0150);

    // R12: window write takes effect next cycle
    rng_we = 1'b1; rng_sel = 2'd0; rng_base = 16'h0000; rng_limit = 16'h0000;
    fetch_valid = 1'b1; fetch_word = ext_word(6'd7);
    tick();
    rng_we = 1'b0;
    chk("R12 old window start", {28'd0, cu_start}, 32'b0001);
    chk("R12 old window local", {16'd0, cu_local_idx}, 32'h00FF);
    tick();
    fetch_valid = 1'b0;
    chk("R12 new window illegal", {31'd0, ext_illegal}, 32'd1);
    chk("R12 new window no start", {28'd0, cu_start}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule